// File: doc/BRIEF.md
# Sequential Fixed-Point Square Root

This block takes an unsigned integer operand and computes its square root with a whole part and a fraction part. It works bit by bit with a restoring method, one result bit per clock, on a clock that never stops. A one-cycle start strobe presents the operand. The block skips the leading operand bit pairs that are zero, so small operands give a whole result sooner.

The whole part of the root appears first on a shared result bus, together with a one-cycle whole-valid pulse. The loop then continues with zero bit pairs shifted in to make the fraction bits. The fraction appears on the same bus a fixed number of cycles later, together with a one-cycle fraction-valid pulse. The block handles one operand at a time. A start strobe that arrives during a computation is dropped.

Top module: `fxsqrt_seq`

## Requirements
- R1: When the block is idle and `start_i` is high at a rising clock edge, `operand_i` is captured at that edge and a computation begins.
- R2: The whole result placed on `res_o` during the `whole_vld_o` pulse equals floor(sqrt(x)), where x is the captured operand.
- R3: `whole_vld_o` is high in the cycle after the (n+1)-th rising edge that follows the capture edge. Here n is one plus the index of the highest operand pair that is nonzero, where pair i is bits [2i+1:2i], and n is 0 for x = 0.
- R4: `frac_vld_o` rises exactly FRAC_W+1 cycles after `whole_vld_o`. During that pulse `res_o` carries floor(sqrt(x)*2^FRAC_W) mod 2^FRAC_W, and the upper bits are zero.
- R5: An operand of 0 gives a whole result of 0 after one edge, and a fraction result of 0.
- R6: A `start_i` strobe from the capture edge up to and including the edge that raises `frac_vld_o` has no effect, whatever value `operand_i` carries.
- R7: After reset, `res_o`, `whole_vld_o` and `frac_vld_o` are 0. Between pulses, `res_o` holds the last result it presented.
- R8: Each valid pulse lasts one cycle, there is exactly one of each per operand, and the two pulses are never high together.
- R9: The largest operand (all ones) gives a whole result of 255 and a fraction of 255 with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | Operand strobe |
| operand_i | input | IN_W | Unsigned operand |
| res_o | output | max(IN_W/2, FRAC_W) | Shared result bus for the whole part, then the fraction part |
| whole_vld_o | output | 1 | One-cycle pulse: the whole part is on `res_o` |
| frac_vld_o | output | 1 | One-cycle pulse: the fraction part is on `res_o` |

## Verification
The bench builds the block with IN_W = 16 and FRAC_W = 8. At this size every one of the nine whole-part latency classes can be reached, from the zero operand up to operands with a nonzero top pair. Random operands are masked to a random number of significant pairs so that each class is hit many times. Directed cases cover zero, small values, exact squares, powers of four and the all-ones operand. Extra start strobes are driven during busy periods to show they are dropped.

// File: rtl/sqrt_pkg.sv
package sqrt_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WHOLE = 2'd1,
    ST_FRAC  = 2'd2
  } sq_state_e;
endpackage

// File: rtl/sqrt_rst_sync.sv
module sqrt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/sqrt_lead_pairs.sv
module sqrt_lead_pairs #(
  parameter int IN_W  = 16,
  parameter int CNT_W = 4
) (
  input  logic [IN_W-1:0]  value_i,
  output logic [CNT_W-1:0] sig_pairs_o,
  output logic [IN_W-1:0]  aligned_o
);
  localparam int PAIRS = IN_W / 2;

  logic [CNT_W-1:0] sig;

  always_comb begin
    sig = '0;
    for (int i = 0; i < PAIRS; i++) begin
      if (value_i[2*i +: 2] != 2'b00) sig = CNT_W'(i + 1);
    end
  end

  always_comb begin
    aligned_o = value_i << (2 * (PAIRS - int'(sig)));
  end

  assign sig_pairs_o = sig;
endmodule

// File: rtl/sqrt_step.sv
module sqrt_step #(
  parameter int ROOT_W = 16,
  parameter int REM_W  = 19
) (
  input  logic [REM_W-1:0]  rem_i,
  input  logic [ROOT_W-1:0] root_i,
  input  logic [1:0]        pair_i,
  output logic [REM_W-1:0]  rem_o,
  output logic [ROOT_W-1:0] root_o
);
  logic [REM_W-1:0] rem_sh;
  logic [REM_W-1:0] trial;

  always_comb begin
    rem_sh = {rem_i[REM_W-3:0], pair_i};
    trial  = REM_W'({root_i, 2'b01});
    if (rem_sh >= trial) begin
      rem_o  = rem_sh - trial;
      root_o = {root_i[ROOT_W-2:0], 1'b1};
    end else begin
      rem_o  = rem_sh;
      root_o = {root_i[ROOT_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/sqrt_ctrl.sv
module sqrt_ctrl
  import sqrt_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [IN_W-1:0]   operand_i,
  output logic [((IN_W/2) > FRAC_W ? (IN_W/2) : FRAC_W)-1:0] res_o,
  output logic              whole_vld_o,
  output logic              frac_vld_o
);
  localparam int HALF_W = IN_W / 2;
  localparam int PAIRS  = HALF_W;
  localparam int ROOT_W = HALF_W + FRAC_W;
  localparam int REM_W  = ROOT_W + 3;
  localparam int OUT_W  = (HALF_W > FRAC_W) ? HALF_W : FRAC_W;
  localparam int MAXC   = (PAIRS > FRAC_W) ? PAIRS : FRAC_W;
  localparam int CNT_W  = $clog2(MAXC + 1);

  sq_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IN_W-1:0]  opr_q, opr_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [ROOT_W-1:0] root_q, root_d;
  logic [OUT_W-1:0] res_q, res_d;
  logic             whole_q, whole_d;
  logic             frac_q, frac_d;

  logic             work_en;
  logic             res_en;

  logic [CNT_W-1:0] sig_pairs;
  logic [IN_W-1:0]  aligned;
  logic [REM_W-1:0] rem_step;
  logic [ROOT_W-1:0] root_step;

  sqrt_lead_pairs #(.IN_W(IN_W), .CNT_W(CNT_W)) lead_i (
    .value_i    (operand_i),
    .sig_pairs_o(sig_pairs),
    .aligned_o  (aligned)
  );

  sqrt_step #(.ROOT_W(ROOT_W), .REM_W(REM_W)) step_i (
    .rem_i (rem_q),
    .root_i(root_q),
    .pair_i(opr_q[IN_W-1 -: 2]),
    .rem_o (rem_step),
    .root_o(root_step)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    opr_d   = opr_q;
    rem_d   = rem_q;
    root_d  = root_q;
    res_d   = res_q;
    whole_d = 1'b0;
    frac_d  = 1'b0;
    work_en = 1'b0;
    res_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          work_en = 1'b1;
          state_d = ST_WHOLE;
          cnt_d   = sig_pairs;
          opr_d   = aligned;
          rem_d   = '0;
          root_d  = '0;
        end
      end
      ST_WHOLE: begin
        work_en = 1'b1;
        if (cnt_q != '0) begin
          cnt_d  = cnt_q - 1'b1;
          opr_d  = opr_q << 2;
          rem_d  = rem_step;
          root_d = root_step;
        end else begin
          res_en  = 1'b1;
          res_d   = OUT_W'(root_q[HALF_W-1:0]);
          whole_d = 1'b1;
          state_d = ST_FRAC;
          cnt_d   = CNT_W'(FRAC_W);
        end
      end
      ST_FRAC: begin
        work_en = 1'b1;
        if (cnt_q != '0) begin
          cnt_d  = cnt_q - 1'b1;
          opr_d  = opr_q << 2;
          rem_d  = rem_step;
          root_d = root_step;
        end else begin
          res_en  = 1'b1;
          res_d   = OUT_W'(root_q[FRAC_W-1:0]);
          frac_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: begin
        work_en = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      opr_q   <= '0;
      rem_q   <= '0;
      root_q  <= '0;
      res_q   <= '0;
      whole_q <= 1'b0;
      frac_q  <= 1'b0;
    end else begin
      whole_q <= whole_d;
      frac_q  <= frac_d;
      if (work_en) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
        opr_q   <= opr_d;
        rem_q   <= rem_d;
        root_q  <= root_d;
      end
      if (res_en) res_q <= res_d;
    end
  end

  assign res_o       = res_q;
  assign whole_vld_o = whole_q;
  assign frac_vld_o  = frac_q;

  // restoring invariant: partial remainder never exceeds twice the partial root
  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> ({1'b0, rem_q} <= (REM_W+1)'({root_q, 1'b0})));

  // a strobe while busy must not reload the counter
  assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && cnt_q != '0) |=>
      (cnt_q == $past(cnt_q) - 1'b1 && state_q == $past(state_q)));

  assert_whole_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    whole_q |=> !whole_q);

  assert_frac_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frac_q |=> !frac_q);

  assert_pulse_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(whole_q && frac_q));

  assert_res_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!whole_q && !frac_q) |-> $stable(res_q) || $past(!rst_n));
endmodule

// File: rtl/fxsqrt_seq.sv
module fxsqrt_seq #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [IN_W-1:0] operand_i,
  output logic [((IN_W/2) > FRAC_W ? (IN_W/2) : FRAC_W)-1:0] res_o,
  output logic            whole_vld_o,
  output logic            frac_vld_o
);
  localparam int GAP_MAX = FRAC_W + 2;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  logic rst_sync_n;

  sqrt_rst_sync #(.STAGES(2)) rst_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  sqrt_ctrl #(.IN_W(IN_W), .FRAC_W(FRAC_W)) ctrl_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start_i    (start_i),
    .operand_i  (operand_i),
    .res_o      (res_o),
    .whole_vld_o(whole_vld_o),
    .frac_vld_o (frac_vld_o)
  );

  // cycles elapsed since the last whole pulse, saturating
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                                gap_q <= '0;
    else if (whole_vld_o)                           gap_q <= GAP_W'(1);
    else if (gap_q != '0 && gap_q != GAP_W'(GAP_MAX)) gap_q <= gap_q + 1'b1;
  end

  assert_frac_gap_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    frac_vld_o |-> (gap_q == GAP_W'(FRAC_W + 1)));
endmodule

// File: tb/fxsqrt_seq_tb_top.sv
module fxsqrt_seq_tb_top;
  localparam int IN_W   = 16;
  localparam int FRAC_W = 8;
  localparam int OUT_W  = 8;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic [IN_W-1:0]  operand_i;
  logic [OUT_W-1:0] res_o;
  logic             whole_vld_o;
  logic             frac_vld_o;

  int n_chk;
  int n_bad;
  bit done;

  fxsqrt_seq #(.IN_W(IN_W), .FRAC_W(FRAC_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .operand_i  (operand_i),
    .res_o      (res_o),
    .whole_vld_o(whole_vld_o),
    .frac_vld_o (frac_vld_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic int unsigned isqrt(longint unsigned v);
    longint unsigned r;
    r = 0;
    for (int b = 15; b >= 0; b--) begin
      longint unsigned t;
      t = r | (longint'(1) << b);
      if (t * t <= v) r = t;
    end
    return int'(r);
  endfunction

  function automatic int sig_pairs(logic [IN_W-1:0] x);
    int n;
    n = 0;
    for (int i = 0; i < IN_W / 2; i++) if (x[2*i +: 2] != 2'b00) n = i + 1;
    return n;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(logic [IN_W-1:0] x, bit junk);
    int n, r, ew, ef, wcyc, fcyc, wcnt, fcnt, wval, fval, both;
    bit hold_ok;
    n  = sig_pairs(x);
    r  = isqrt({32'h0, x, 16'h0});
    ew = (r >> 8) & 255;
    ef = r & 255;
    wcyc = -1; fcyc = -1; wcnt = 0; fcnt = 0; wval = -1; fval = -1; both = 0;
    hold_ok = 1'b1;
    @(negedge clk);
    start_i   = 1'b1;
    operand_i = x;
    @(posedge clk);
    @(negedge clk);
    start_i   = junk;
    operand_i = IN_W'($urandom);
    for (int k = 1; k <= n + 10; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (whole_vld_o && frac_vld_o) both++;
      if (whole_vld_o) begin wcnt++; wcyc = k; wval = int'(res_o); end
      if (frac_vld_o)  begin fcnt++; fcyc = k; fval = int'(res_o); end
      if (wcyc > 0 && fcyc < 0 && !whole_vld_o && int'(res_o) != wval) hold_ok = 1'b0;
      if (k >= n + 9) start_i = 1'b0;
      else            start_i = junk & $urandom_range(1, 0);
      operand_i = IN_W'($urandom);
    end
    start_i = 1'b0;
    // R3 whole latency
    chk(wcnt == 1 && wcyc == n + 1, "R3 whole latency", wcyc, n + 1);
    // R2 whole value (R5 zero, R9 max, R6 junk strobes)
    chk(wval == ew, x == 0 ? "R5 whole of zero" :
                    (x == '1 ? "R9 whole of max" : (junk ? "R6 whole with busy strobes" : "R2 whole value")),
        wval, ew);
    // R4 fraction timing and value
    chk(fcnt == 1 && fcyc == n + 10, "R4 fraction latency", fcyc, n + 10);
    chk(fval == ef, x == 0 ? "R5 fraction of zero" :
                    (x == '1 ? "R9 fraction of max" : (junk ? "R6 fraction with busy strobes" : "R4 fraction value")),
        fval, ef);
    // R8 pulses exclusive
    chk(both == 0, "R8 overlapping pulses", both, 0);
    // R7 hold between pulses
    chk(hold_ok, "R7 hold whole until fraction", int'(hold_ok), 1);
    @(posedge clk);
    @(negedge clk);
    chk(!whole_vld_o && !frac_vld_o && int'(res_o) == ef, "R7 idle after fraction",
        int'(res_o), ef);
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [IN_W-1:0] dir [10];
    int unsigned seed;
    n_chk = 0;
    n_bad = 0;
    seed = $urandom(32'h5eed_0042);
    rst_n     = 1'b0;
    start_i   = 1'b0;
    operand_i = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7 reset state
    chk(res_o == '0 && !whole_vld_o && !frac_vld_o, "R7 reset state", int'(res_o), 0);

    // R1 capture: first directed operand
    dir = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0004,
            16'hFFFF, 16'h4000, 16'h0100, 16'h00FF, 16'h3FFF};
    foreach (dir[i]) run_op(dir[i], 1'b0);
    run_op(16'h0000, 1'b1);
    run_op(16'hFFFF, 1'b1);
    run_op(16'h0010, 1'b1);

    for (int i = 0; i < 200; i++) begin
      logic [IN_W-1:0] x;
      int sh;
      sh = $urandom_range(7, 0);
      x  = IN_W'($urandom) & (16'hFFFF >> (2 * sh));
      run_op(x, i[0]);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule